// File: doc/BRIEF.md
# Tag-Snooping Reservation Station Array

This block is a small pool of waiting slots for one class of functional unit in an out-of-order datapath. Each slot is filled by an issue request that carries an opcode and two source operands. A source operand arrives in one of two forms. It is either a finished value, marked by a producer tag of zero, or the nonzero tag of the slot that will compute it. A slot that is still waiting on a tag watches a single broadcast result bus. When that tag appears on the bus, the slot takes the value in the same clock, so one broadcast can release any number of consumers.

A slot whose operands are all present competes for the functional unit. The array offers the lowest-numbered such slot through a valid/ready dispatch handshake and frees the slot once the unit accepts it. Every slot owns a fixed, nonzero tag. The issue side sees the tag of the slot it is about to fill, and it records that tag as the pending producer of the destination register. A value taken at issue is never replaced by later writes to the same architectural register. The issue logic forwards a result that is broadcast in the same cycle as the issue, so that wakeup is not lost.

Top module: `tag_wakeup_station_pool`

## Requirements
- R1: After reset all slots are free: `iss_ready` is 1 and `disp_valid` is 0.
- R2: An issued source whose tag is 0 is stored as a ready value, and that exact value is later presented on `disp_a` / `disp_b` together with the issued opcode on `disp_op`.
- R3: A source issued with a nonzero tag keeps its slot from dispatching until a valid broadcast carries that tag.
- R4: A valid broadcast whose tag matches a waiting source loads `bus_val` into that source in every slot that waits on it, on the same clock edge. A slot whose last source is filled this way can dispatch in the next cycle.
- R5: If a valid broadcast carries a source's nonzero tag in the cycle that the source is issued, the slot stores `bus_val` as a ready operand.
- R6: A source held as a ready value is never changed by any later broadcast.
- R7: When several slots are ready, the one with the lowest index is presented for dispatch.
- R8: A presented slot stays busy and dispatchable while `disp_ready` is 0. It is freed on the edge where `disp_valid` and `disp_ready` are both 1.
- R9: `iss_ready` is 0 exactly when every slot is busy, and an issue attempted while all slots are busy has no effect.
- R10: Slot i owns tag `TAG_BASE + i`, which is never 0. `iss_tag` gives the tag of the lowest-indexed free slot, which is the slot the next issue fills. `disp_tag` gives the tag of the slot being dispatched.
- R11: While `bus_valid` is 0, the bus fields wake no slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | A free slot exists |
| iss_tag | output | TAG_W | Tag of the slot the next issue fills |
| iss_op | input | OP_W | Opcode to store |
| iss_src1_tag | input | TAG_W | First source producer tag, 0 = value present |
| iss_src1_val | input | DATA_W | First source value |
| iss_src2_tag | input | TAG_W | Second source producer tag, 0 = value present |
| iss_src2_val | input | DATA_W | Second source value |
| bus_valid | input | 1 | Result broadcast present |
| bus_tag | input | TAG_W | Tag of the broadcasting producer |
| bus_val | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A ready slot is offered |
| disp_ready | input | 1 | Functional unit takes the offered slot |
| disp_op | output | OP_W | Opcode of the offered slot |
| disp_a | output | DATA_W | First operand of the offered slot |
| disp_b | output | DATA_W | Second operand of the offered slot |
| disp_tag | output | TAG_W | Tag of the offered slot |

## Verification
The slot state changes only on the clock edge. `iss_ready`, `iss_tag` and every dispatch output are combinational from that state, so they reflect the state the current cycle started with. An issue or a wakeup at edge k first appears at the dispatch port in the cycle after edge k, and a slot released at edge k stops being offered in that same following cycle. The bench drives inputs on the falling edge and compares every output against its reference model one time unit later, well before the next rising edge. It then advances the model with the same inputs at the rising edge, so each result is checked in the cycle it is due.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;
   parameter int RSP_ENTRIES  = 4;
   parameter int RSP_TAG_W    = 4;
   parameter int RSP_DATA_W   = 16;
   parameter int RSP_OP_W     = 4;
   parameter int RSP_TAG_BASE = 1;
endpackage

// File: rtl/rs_pick_first.sv
module rs_pick_first #(
   parameter int N     = 4,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      found_o = |req_i;
      idx_o   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end
endmodule

// File: rtl/rs_src_resolve.sv
module rs_src_resolve #(
   parameter int DATA_W = 16,
   parameter int TAG_W  = 4
) (
   input  logic [TAG_W-1:0]  src_tag_i,
   input  logic [DATA_W-1:0] src_val_i,
   input  logic              bus_valid_i,
   input  logic [TAG_W-1:0]  bus_tag_i,
   input  logic [DATA_W-1:0] bus_val_i,
   output logic [TAG_W-1:0]  q_o,
   output logic [DATA_W-1:0] v_o
);
   // same-cycle forwarding of a broadcast to an operand being issued
   always_comb begin
      if (src_tag_i != '0 && bus_valid_i && bus_tag_i == src_tag_i) begin
         q_o = '0;
         v_o = bus_val_i;
      end else begin
         q_o = src_tag_i;
         v_o = src_val_i;
      end
   end
endmodule

// File: rtl/rs_slot.sv
module rs_slot #(
   parameter int DATA_W = 16,
   parameter int TAG_W  = 4,
   parameter int OP_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_i,
   input  logic [OP_W-1:0]   alloc_op_i,
   input  logic [TAG_W-1:0]  alloc_qj_i,
   input  logic [DATA_W-1:0] alloc_vj_i,
   input  logic [TAG_W-1:0]  alloc_qk_i,
   input  logic [DATA_W-1:0] alloc_vk_i,
   input  logic              bus_valid_i,
   input  logic [TAG_W-1:0]  bus_tag_i,
   input  logic [DATA_W-1:0] bus_val_i,
   input  logic              release_i,
   output logic              busy_o,
   output logic              ready_o,
   output logic [OP_W-1:0]   op_o,
   output logic [DATA_W-1:0] vj_o,
   output logic [DATA_W-1:0] vk_o
);
   logic [TAG_W-1:0] qj_q, qk_q;
   logic             hit_j, hit_k;

   assign hit_j   = busy_o && bus_valid_i && qj_q != '0 && qj_q == bus_tag_i;
   assign hit_k   = busy_o && bus_valid_i && qk_q != '0 && qk_q == bus_tag_i;
   assign ready_o = busy_o && qj_q == '0 && qk_q == '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         op_o   <= '0;
         qj_q   <= '0;
         qk_q   <= '0;
         vj_o   <= '0;
         vk_o   <= '0;
      end else if (alloc_i) begin
         busy_o <= 1'b1;
         op_o   <= alloc_op_i;
         qj_q   <= alloc_qj_i;
         qk_q   <= alloc_qk_i;
         vj_o   <= alloc_vj_i;
         vk_o   <= alloc_vk_i;
      end else begin
         if (release_i) busy_o <= 1'b0;
         if (hit_j) begin
            vj_o <= bus_val_i;
            qj_q <= '0;
         end
         if (hit_k) begin
            vk_o <= bus_val_i;
            qk_q <= '0;
         end
      end
   end
endmodule

// File: rtl/tag_wakeup_station_pool.sv
module tag_wakeup_station_pool
   import rs_pool_pkg::*;
#(
   parameter int NUM_ENTRIES = RSP_ENTRIES,
   parameter int TAG_W       = RSP_TAG_W,
   parameter int DATA_W      = RSP_DATA_W,
   parameter int OP_W        = RSP_OP_W,
   parameter int TAG_BASE    = RSP_TAG_BASE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              iss_valid,
   output logic              iss_ready,
   output logic [TAG_W-1:0]  iss_tag,
   input  logic [OP_W-1:0]   iss_op,
   input  logic [TAG_W-1:0]  iss_src1_tag,
   input  logic [DATA_W-1:0] iss_src1_val,
   input  logic [TAG_W-1:0]  iss_src2_tag,
   input  logic [DATA_W-1:0] iss_src2_val,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_val,
   output logic              disp_valid,
   input  logic              disp_ready,
   output logic [OP_W-1:0]   disp_op,
   output logic [DATA_W-1:0] disp_a,
   output logic [DATA_W-1:0] disp_b,
   output logic [TAG_W-1:0]  disp_tag
);
   localparam int IDX_W    = $clog2(NUM_ENTRIES);
   localparam int LAST_TAG = TAG_BASE + NUM_ENTRIES - 1;

   if (NUM_ENTRIES < 2) begin : g_bad_depth
      $error("NUM_ENTRIES must be at least 2");
   end
   if (TAG_BASE < 1) begin : g_bad_base
      $error("TAG_BASE must be nonzero; tag 0 means no producer");
   end
   if (LAST_TAG >= (1 << TAG_W)) begin : g_bad_tagw
      $error("TAG_W too narrow for the slot tags");
   end

   logic [NUM_ENTRIES-1:0] busy_v, ready_v, rel_v;
   logic [OP_W-1:0]        op_a [NUM_ENTRIES];
   logic [DATA_W-1:0]      vj_a [NUM_ENTRIES];
   logic [DATA_W-1:0]      vk_a [NUM_ENTRIES];
   logic                   free_found, rdy_found, take;
   logic [IDX_W-1:0]       free_idx, rdy_idx;
   logic [TAG_W-1:0]       new_qj, new_qk;
   logic [DATA_W-1:0]      new_vj, new_vk;

   rs_pick_first #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_free_pick (
      .req_i(~busy_v), .found_o(free_found), .idx_o(free_idx));

   rs_pick_first #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_rdy_pick (
      .req_i(ready_v), .found_o(rdy_found), .idx_o(rdy_idx));

   rs_src_resolve #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src1 (
      .src_tag_i(iss_src1_tag), .src_val_i(iss_src1_val),
      .bus_valid_i(bus_valid), .bus_tag_i(bus_tag), .bus_val_i(bus_val),
      .q_o(new_qj), .v_o(new_vj));

   rs_src_resolve #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src2 (
      .src_tag_i(iss_src2_tag), .src_val_i(iss_src2_val),
      .bus_valid_i(bus_valid), .bus_tag_i(bus_tag), .bus_val_i(bus_val),
      .q_o(new_qk), .v_o(new_vk));

   assign iss_ready = free_found;
   assign iss_tag   = TAG_W'(TAG_BASE) + TAG_W'(free_idx);
   assign take      = iss_valid && free_found;

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
      assign rel_v[g] = disp_ready && rdy_found && rdy_idx == IDX_W'(g);
      rs_slot #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .alloc_i(take && free_idx == IDX_W'(g)),
         .alloc_op_i(iss_op),
         .alloc_qj_i(new_qj), .alloc_vj_i(new_vj),
         .alloc_qk_i(new_qk), .alloc_vk_i(new_vk),
         .bus_valid_i(bus_valid), .bus_tag_i(bus_tag), .bus_val_i(bus_val),
         .release_i(rel_v[g]),
         .busy_o(busy_v[g]), .ready_o(ready_v[g]),
         .op_o(op_a[g]), .vj_o(vj_a[g]), .vk_o(vk_a[g]));
   end

   assign disp_valid = rdy_found;
   assign disp_op    = op_a[rdy_idx];
   assign disp_a     = vj_a[rdy_idx];
   assign disp_b     = vk_a[rdy_idx];
   assign disp_tag   = TAG_W'(TAG_BASE) + TAG_W'(rdy_idx);
endmodule

// File: rtl/rs_pool_chk.sv
module rs_pool_chk #(
   parameter int NUM_ENTRIES = 4,
   parameter int TAG_W       = 4,
   parameter int TAG_BASE    = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             iss_valid,
   input logic             iss_ready,
   input logic [TAG_W-1:0] iss_tag,
   input logic             disp_valid,
   input logic             disp_ready,
   input logic [TAG_W-1:0] disp_tag
);
   localparam int OCC_W    = $clog2(NUM_ENTRIES + 1);
   localparam int LAST_TAG = TAG_BASE + NUM_ENTRIES - 1;

   logic [OCC_W-1:0] occ_q;
   always_ff @(posedge clk) begin
      if (!rst_n) occ_q <= '0;
      else occ_q <= occ_q + OCC_W'(iss_valid && iss_ready)
                          - OCC_W'(disp_valid && disp_ready);
   end

   // R1
   empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q == '0 |-> !disp_valid);
   // R9
   full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_ready == (occ_q != OCC_W'(NUM_ENTRIES)));
   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid && !disp_ready |=> disp_valid);
   // R10
   disp_tag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      disp_valid |-> disp_tag >= TAG_W'(TAG_BASE) && disp_tag <= TAG_W'(LAST_TAG));
   // R10
   iss_tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_ready |-> iss_tag != '0);
endmodule

bind tag_wakeup_station_pool rs_pool_chk #(
   .NUM_ENTRIES(NUM_ENTRIES), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE)
) u_rs_pool_chk (
   .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
   .iss_tag(iss_tag), .disp_valid(disp_valid), .disp_ready(disp_ready),
   .disp_tag(disp_tag));

// File: tb/test_tag_wakeup_station_pool.sv
module test_tag_wakeup_station_pool;
   localparam int N = 4, TW = 4, DW = 16, OW = 4, TB = 1;

   logic clk = 1'b0, rst_n = 1'b0;
   logic iss_valid = 1'b0, bus_valid = 1'b0, disp_ready = 1'b0;
   logic iss_ready, disp_valid;
   logic [TW-1:0] iss_tag, disp_tag, iss_src1_tag = '0, iss_src2_tag = '0, bus_tag = '0;
   logic [DW-1:0] iss_src1_val = '0, iss_src2_val = '0, bus_val = '0, disp_a, disp_b;
   logic [OW-1:0] iss_op = '0, disp_op;

   always #2 clk = ~clk;

   tag_wakeup_station_pool #(.NUM_ENTRIES(N), .TAG_W(TW), .DATA_W(DW),
      .OP_W(OW), .TAG_BASE(TB)) i_tag_wakeup_station_pool (.*);

   int vectors = 0, miscompares = 0;
   string cur_req = "R1";
   bit m_busy [N];
   int m_op [N], m_qj [N], m_qk [N], m_vj [N], m_vk [N];

   function automatic int first_free();
      for (int i = 0; i < N; i++) if (!m_busy[i]) return i;
      return -1;
   endfunction
   function automatic int first_ready();
      for (int i = 0; i < N; i++)
         if (m_busy[i] && m_qj[i] == 0 && m_qk[i] == 0) return i;
      return -1;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare();
      int f, d;
      f = first_free();
      d = first_ready();
      check(iss_ready === (f >= 0), "R9", int'(iss_ready), int'(f >= 0));
      if (f >= 0) check(iss_tag === TW'(TB + f), "R10", int'(iss_tag), TB + f);
      check(disp_valid === (d >= 0), cur_req, int'(disp_valid), int'(d >= 0));
      if (d >= 0) begin
         check(disp_tag === TW'(TB + d), "R10", int'(disp_tag), TB + d);
         check(int'(disp_op) == m_op[d], "R2", int'(disp_op), m_op[d]);
         check(int'(disp_a) == m_vj[d], cur_req, int'(disp_a), m_vj[d]);
         check(int'(disp_b) == m_vk[d], cur_req, int'(disp_b), m_vk[d]);
      end
   endtask

   task automatic resolve(int t, int v, output int q, output int val);
      if (t != 0 && bus_valid && int'(bus_tag) == t) begin q = 0; val = int'(bus_val); end
      else begin q = t; val = v; end
   endtask

   task automatic model_step();
      int f, d;
      f = first_free();
      d = first_ready();
      for (int i = 0; i < N; i++) if (m_busy[i] && bus_valid) begin
         if (m_qj[i] != 0 && m_qj[i] == int'(bus_tag)) begin m_vj[i] = int'(bus_val); m_qj[i] = 0; end
         if (m_qk[i] != 0 && m_qk[i] == int'(bus_tag)) begin m_vk[i] = int'(bus_val); m_qk[i] = 0; end
      end
      if (d >= 0 && disp_ready) m_busy[d] = 1'b0;
      if (iss_valid && f >= 0) begin
         m_busy[f] = 1'b1;
         m_op[f] = int'(iss_op);
         resolve(int'(iss_src1_tag), int'(iss_src1_val), m_qj[f], m_vj[f]);
         resolve(int'(iss_src2_tag), int'(iss_src2_val), m_qk[f], m_vk[f]);
      end
   endtask

   task automatic cycle();
      #1;
      compare();
      @(posedge clk);
      if (rst_n) model_step();
      @(negedge clk);
   endtask

   task automatic issue(int op, int t1, int v1, int t2, int v2);
      iss_valid = 1'b1; iss_op = OW'(op);
      iss_src1_tag = TW'(t1); iss_src1_val = DW'(v1);
      iss_src2_tag = TW'(t2); iss_src2_val = DW'(v2);
      cycle();
      iss_valid = 1'b0;
   endtask

   task automatic bcast(int t, int v);
      bus_valid = 1'b1; bus_tag = TW'(t); bus_val = DW'(v);
      cycle();
      bus_valid = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      #(200000 * 4);
      vectors++; miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_busy[i] = 0; m_op[i] = 0; m_qj[i] = 0; m_qk[i] = 0; m_vj[i] = 0; m_vk[i] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check(iss_ready === 1'b1, "R1", int'(iss_ready), 1);
      check(disp_valid === 1'b0, "R1", int'(disp_valid), 0);
      @(negedge clk);
      idle(2);

      // R2: ready operands, held a cycle by disp_ready low (R8)
      cur_req = "R2";
      issue(3, 0, 'h1234, 0, 'h00ff);
      cur_req = "R8";
      idle(2);
      disp_ready = 1'b1;
      cur_req = "R2";
      idle(2);

      // R3 and R4: two slots wait on tag 9, one per operand side
      cur_req = "R3";
      issue(5, 9, 0, 0, 'h0022);
      issue(6, 0, 'h0033, 9, 0);
      idle(3);
      // R11: invalid bus with matching tag wakes nothing
      cur_req = "R11";
      bus_valid = 1'b0; bus_tag = 4'd9; bus_val = 16'hdead;
      idle(2);
      cur_req = "R4";
      bcast(9, 'h5a5a);
      idle(3);

      // R5: broadcast in the issue cycle is forwarded
      cur_req = "R5";
      bus_valid = 1'b1; bus_tag = 4'd7; bus_val = 16'h0777;
      issue(2, 7, 0, 7, 0);
      bus_valid = 1'b0;
      idle(2);

      // R6: ready values survive later broadcasts
      cur_req = "R6";
      disp_ready = 1'b0;
      issue(4, 0, 'h0101, 0, 'h0202);
      bcast(0, 'hbeef);
      bcast(1, 'hbeef);
      disp_ready = 1'b1;
      idle(2);

      // R7: lowest ready slot first
      cur_req = "R7";
      disp_ready = 1'b0;
      issue(1, 0, 'h11, 0, 'h12);
      issue(2, 0, 'h21, 0, 'h22);
      issue(3, 0, 'h31, 0, 'h32);
      disp_ready = 1'b1;
      idle(4);

      // R9: fill all slots, then an issue attempt while full
      cur_req = "R9";
      disp_ready = 1'b0;
      for (int i = 0; i < N; i++) issue(8 + i, 10, 0, 0, i);
      issue(15, 0, 'hffff, 0, 'hffff);
      bcast(10, 'h0abc);
      disp_ready = 1'b1;
      idle(6);

      // R4: mixed random traffic
      cur_req = "R4";
      for (int k = 0; k < 600; k++) begin
         int tsel [6];
         tsel = '{0, 1, 2, 3, 9, 10};
         iss_valid    = ($urandom_range(0, 2) != 0);
         iss_op       = OW'($urandom);
         iss_src1_tag = TW'(tsel[$urandom_range(0, 5)]);
         iss_src2_tag = TW'(tsel[$urandom_range(0, 5)]);
         iss_src1_val = DW'($urandom);
         iss_src2_val = DW'($urandom);
         bus_valid    = ($urandom_range(0, 1) != 0);
         bus_tag      = TW'(tsel[$urandom_range(1, 5)]);
         bus_val      = DW'($urandom);
         disp_ready   = ($urandom_range(0, 3) != 0);
         cycle();
      end
      iss_valid = 1'b0; bus_valid = 1'b0;
      idle(2);
      finish_run();
   end
endmodule